// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers eight level-sensitive interrupt request lines from peripheral modules. It resolves them by fixed priority and presents one interrupt request to the processor. The processor answers with an acknowledge. During that acknowledge cycle the controller drives an 8-bit vector onto the data bus. The vector is a programmable base combined with the number of the winning line, so the processor can go straight to the right handler without polling each module.

The controller records which levels are being serviced. A request from a more urgent line can preempt a level that is already in service. Requests of equal or lower urgency wait until the processor ends that service with an end-of-interrupt strobe that names the level. A per-line mask hides lines from the pending logic.

Top module: `pic_vectored`

## Requirements
- R1: While rst_ni is low and after it is released with no request active, int_o is 0, vec_oe_o is 0 and vec_o is 0. The mask and the vector base reset to all zeros.
- R2: An unmasked request that is high at a rising clock edge becomes pending at that edge. When no level is in service, int_o is high in the cycle that follows the edge.
- R3: Line 0 has the highest priority and line 7 the lowest. When several lines are pending, the lowest-numbered one wins.
- R4: vec_oe_o is 1 only in a cycle where inta_i and int_o are both 1. In that cycle vec_o[7:3] holds the vector base and vec_o[2:0] holds the winning line number. In every other cycle vec_oe_o and vec_o are 0.
- R5: At the clock edge that ends an acknowledge cycle, the winning line leaves the pending set and enters the in-service set.
- R6: While levels are in service, int_o is 1 only if a pending line has a lower number than every in-service level. Pending lines of equal or higher number keep waiting.
- R7: A clock edge with eoi_i high removes level eoi_lvl_i (3 bits) from the in-service set. A request that was waiting behind that level then raises int_o.
- R8: A request that drops before it is acknowledged leaves the pending set at the next edge and is never serviced.
- R9: A line whose mask bit (mask_i bit n, loaded by mask_we_i) is 1 is not made pending. Writing the mask does not change the in-service set.
- R10: A base_we_i edge loads base_i. Every later vector carries the new base in bits 7:3.
- R11: An acknowledge given while int_o is 0 drives no vector and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Level-sensitive request lines, bit n is line n |
| mask_we_i | input | 1 | Load mask register |
| mask_i | input | 8 | New mask, 1 hides the line |
| base_we_i | input | 1 | Load vector base |
| base_i | input | 5 | New vector base |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_lvl_i | input | 3 | Level that the strobe retires |
| inta_i | input | 1 | Processor acknowledge |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector, valid while vec_oe_o is 1 |
| vec_oe_o | output | 1 | Data bus drive enable |

## Verification
The hardest state to reach is a stack of several nested in-service levels. It only comes about when a more urgent line rises while a less urgent one is still being serviced, and when end-of-interrupt strobes then retire the levels out of order, sometimes in the same cycle as a new acknowledge. Directed sequences first build a two-deep nest and unwind it, with an exact vector checked at each step. A long random phase then mixes request changes, acknowledges, strobes aimed mostly at the most urgent in-service level, and mask and base writes. This drives the stack through many depths, and a behavioural model checks every cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_N_LVL  = 8;
  localparam int unsigned PIC_BASE_W = 5;

  function automatic logic [PIC_N_LVL-1:0] lvl_bit(input logic [$clog2(PIC_N_LVL)-1:0] lvl);
    logic [PIC_N_LVL-1:0] r;
    r = '0;
    r[lvl] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    vld_o = |req_i;
  end
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs #(
  parameter int unsigned N      = 8,
  parameter int unsigned BASE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic [N-1:0]      mask_i,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [N-1:0]      mask_q_o,
  output logic [BASE_W-1:0] base_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o <= '0;
      base_q_o <= '0;
    end else begin
      if (mask_we_i) mask_q_o <= mask_i;
      if (base_we_i) base_q_o <= base_i;
    end
  end
endmodule

// File: rtl/pic_track.sv
module pic_track #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic [N-1:0]  mask_i,
  input  logic          ack_i,
  input  logic [IW-1:0] ack_lvl_i,
  input  logic          eoi_i,
  input  logic [IW-1:0] eoi_lvl_i,
  output logic [N-1:0]  pend_q_o,
  output logic [N-1:0]  isr_q_o
);
  logic [N-1:0] ack_bit, eoi_bit;

  always_comb begin
    ack_bit = '0;
    eoi_bit = '0;
    if (ack_i) ack_bit[ack_lvl_i] = 1'b1;
    if (eoi_i) eoi_bit[eoi_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q_o <= '0;
      isr_q_o  <= '0;
    end else begin
      // requests are re-sampled every edge; the acked line skips one sample
      pend_q_o <= irq_i & ~mask_i & ~ack_bit;
      isr_q_o  <= (isr_q_o & ~eoi_bit) | ack_bit;
    end
  end
endmodule

// File: rtl/pic_vectored.sv
module pic_vectored #(
  parameter int unsigned N_LVL  = pic_pkg::PIC_N_LVL,
  parameter int unsigned BASE_W = pic_pkg::PIC_BASE_W,
  localparam int unsigned LVL_W = $clog2(N_LVL),
  localparam int unsigned VEC_W = BASE_W + LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LVL-1:0]  irq_i,
  input  logic              mask_we_i,
  input  logic [N_LVL-1:0]  mask_i,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              eoi_i,
  input  logic [LVL_W-1:0]  eoi_lvl_i,
  input  logic              inta_i,
  output logic              int_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_oe_o
);
  logic [N_LVL-1:0]  mask_q, pend_q, isr_q;
  logic [BASE_W-1:0] base_q;
  logic              pend_vld, isr_vld, ack;
  logic [LVL_W-1:0]  pend_idx, isr_idx;

  pic_cfg_regs #(.N(N_LVL), .BASE_W(BASE_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(mask_we_i),
    .mask_i   (mask_i),
    .base_we_i(base_we_i),
    .base_i   (base_i),
    .mask_q_o (mask_q),
    .base_q_o (base_q)
  );

  pic_track #(.N(N_LVL)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .mask_i   (mask_q),
    .ack_i    (ack),
    .ack_lvl_i(pend_idx),
    .eoi_i    (eoi_i),
    .eoi_lvl_i(eoi_lvl_i),
    .pend_q_o (pend_q),
    .isr_q_o  (isr_q)
  );

  pic_prio_enc #(.N(N_LVL)) u_pend_enc (.req_i(pend_q), .vld_o(pend_vld), .idx_o(pend_idx));
  pic_prio_enc #(.N(N_LVL)) u_isr_enc  (.req_i(isr_q),  .vld_o(isr_vld),  .idx_o(isr_idx));

  // a pending line may interrupt only if it outranks every level in service
  assign int_o    = pend_vld && (!isr_vld || (pend_idx < isr_idx));
  assign ack      = inta_i && int_o;
  assign vec_oe_o = ack;
  assign vec_o    = ack ? {base_q, pend_idx} : '0;
endmodule

// File: rtl/pic_vectored_chk.sv
module pic_vectored_chk #(
  parameter int unsigned N_LVL  = 8,
  parameter int unsigned BASE_W = 5,
  localparam int unsigned LVL_W = $clog2(N_LVL),
  localparam int unsigned VEC_W = BASE_W + LVL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              int_o,
  input logic              inta_i,
  input logic              eoi_i,
  input logic [LVL_W-1:0]  eoi_lvl_i,
  input logic              vec_oe_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [N_LVL-1:0]  pend_q,
  input logic [N_LVL-1:0]  isr_q,
  input logic [BASE_W-1:0] base_q
);
  p_oe_in_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> (inta_i && int_o));

  p_idle_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_oe_o |-> (vec_o == '0));

  p_vec_base_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> (vec_o[VEC_W-1 -: BASE_W] == base_q));

  p_int_has_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (|pend_q));

  p_ack_grows_isr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !eoi_i) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  p_ack_drops_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o) |=> !pend_q[$past(vec_o[LVL_W-1:0])]);

  p_eoi_retires_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !(inta_i && int_o)) |=> !isr_q[$past(eoi_lvl_i)]);

  p_no_ack_still_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o && !eoi_i) |=> $stable(isr_q));
endmodule

bind pic_vectored pic_vectored_chk #(.N_LVL(N_LVL), .BASE_W(BASE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .int_o    (int_o),
  .inta_i   (inta_i),
  .eoi_i    (eoi_i),
  .eoi_lvl_i(eoi_lvl_i),
  .vec_oe_o (vec_oe_o),
  .vec_o    (vec_o),
  .pend_q   (pend_q),
  .isr_q    (isr_q),
  .base_q   (base_q)
);

// File: tb/pic_vectored_tb.sv
module pic_vectored_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_v = '0;
  logic       base_we = 1'b0;
  logic [4:0] base_v = '0;
  logic       eoi = 1'b0;
  logic [2:0] eoi_lvl = '0;
  logic       inta = 1'b0;
  logic       int_w, oe_w;
  logic [7:0] vec_w;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit [7:0] m_pend = '0, m_isr = '0, m_mask = '0;
  bit [4:0] m_base = '0;

  always #2 clk = ~clk;

  pic_vectored u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .mask_we_i(mask_we), .mask_i(mask_v),
    .base_we_i(base_we), .base_i(base_v),
    .eoi_i(eoi), .eoi_lvl_i(eoi_lvl), .inta_i(inta),
    .int_o(int_w), .vec_o(vec_w), .vec_oe_o(oe_w)
  );

  function automatic int first_one(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit exp_int();
    int p = first_one(m_pend);
    return (p < 8) && (p < first_one(m_isr));
  endfunction

  function automatic bit [7:0] exp_vec();
    if (inta && exp_int()) return {m_base, 3'(first_one(m_pend))};
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0; m_isr <= '0; m_mask <= '0; m_base <= '0;
    end else begin
      bit [7:0] ab, eb;
      ab = '0; eb = '0;
      if (inta && exp_int()) ab[first_one(m_pend)] = 1'b1;
      if (eoi) eb[eoi_lvl] = 1'b1;
      m_pend <= irq & ~m_mask & ~ab;
      m_isr  <= (m_isr & ~eb) | ab;
      if (mask_we) m_mask <= mask_v;
      if (base_we) m_base <= base_v;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    check(cur_req, "int_o", int_w, exp_int());
    check(cur_req, "vec_oe_o", oe_w, inta && exp_int());
    check(cur_req, "vec_o", vec_w, exp_vec());
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic ack_once();
    inta = 1'b1; step(); inta = 1'b0;
  endtask

  task automatic retire(int lvl);
    eoi = 1'b1; eoi_lvl = 3'(lvl); step(); eoi = 1'b0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    cur_req = "R1";
    step(3);
    @(negedge clk);
    check("R1", "int_o in reset", int_w, 0);
    check("R1", "vec_oe_o in reset", oe_w, 0);
    rst_n = 1'b1;
    step(2);

    cur_req = "R10";
    base_we = 1'b1; base_v = 5'h14; step(); base_we = 1'b0;

    cur_req = "R2";
    irq = 8'h08; step();
    @(negedge clk);
    check("R2", "int_o one edge after request", int_w, 1);
    @(posedge clk); #1;

    cur_req = "R4";
    inta = 1'b1;
    @(negedge clk);
    check("R4", "vector base 14 line 3", vec_w, 8'hA3);
    check("R4", "drive enable during ack", oe_w, 1);
    @(posedge clk); #1; inta = 1'b0;

    cur_req = "R5";
    @(negedge clk);
    check("R5", "serviced line held off", int_w, 0);
    @(posedge clk); #1;

    cur_req = "R6";
    irq = 8'h28; step(2);
    @(negedge clk);
    check("R6", "lower line waits", int_w, 0);
    @(posedge clk); #1;
    irq = 8'h2A; step();
    @(negedge clk);
    check("R6", "higher line preempts", int_w, 1);
    @(posedge clk); #1;
    inta = 1'b1;
    @(negedge clk);
    check("R6", "nested vector line 1", vec_w, 8'hA1);
    @(posedge clk); #1; inta = 1'b0;

    cur_req = "R9";
    mask_we = 1'b1; mask_v = 8'h02; step(); mask_we = 1'b0;
    step(2);
    @(negedge clk);
    check("R9", "masking in-service line keeps nest", int_w, 0);
    @(posedge clk); #1;

    cur_req = "R7";
    retire(1); step();
    retire(3); step();
    @(negedge clk);
    check("R7", "line 5 released after retiring 3", int_w, 1);
    @(posedge clk); #1;
    irq = 8'h00;
    mask_we = 1'b1; mask_v = 8'h00; step(); mask_we = 1'b0;

    cur_req = "R11";
    step(2);
    ack_once();
    step();

    cur_req = "R3";
    irq = 8'hC4; step(2);
    inta = 1'b1;
    @(negedge clk);
    check("R3", "lowest number wins", vec_w, 8'hA2);
    @(posedge clk); #1; inta = 1'b0;
    irq = 8'h00; retire(2); step(2);

    cur_req = "R8";
    irq = 8'h10; step(); irq = 8'h00; step();
    @(negedge clk);
    check("R8", "dropped request gone", int_w, 0);
    @(posedge clk); #1;

    cur_req = "R9";
    mask_we = 1'b1; mask_v = 8'h40; step(); mask_we = 1'b0;
    irq = 8'h40; step(2);
    @(negedge clk);
    check("R9", "masked line ignored", int_w, 0);
    @(posedge clk); #1;
    irq = 8'h00; mask_we = 1'b1; mask_v = 8'h00; step(); mask_we = 1'b0;

    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) irq = 8'($urandom);
      inta    = ($urandom_range(0, 3) == 0);
      eoi     = ($urandom_range(0, 4) == 0);
      eoi_lvl = (m_isr != 0 && $urandom_range(0, 3) != 0) ? 3'(first_one(m_isr)) : 3'($urandom);
      mask_we = ($urandom_range(0, 40) == 0);
      mask_v  = 8'($urandom) & 8'($urandom);
      base_we = ($urandom_range(0, 50) == 0);
      base_v  = 5'($urandom);
      step();
    end
    inta = 1'b0; eoi = 1'b0; mask_we = 1'b0; base_we = 1'b0;
    step(2);
    finish_up();
  end
endmodule